// File: doc/BRIEF.md
# Chained Source DMA Channel

This block is one memory-to-FIFO DMA channel. It reads 128-bit quadwords from memory as four 32-bit words and pushes each word into an outbound FIFO. Software sets four channel registers: a control word, a data address, a quadword count and a descriptor address. Setting the start bit launches the channel.

In plain mode the channel moves the programmed count and then stops. In chained mode, each time the count reaches zero, the channel reads a 64-bit descriptor from the descriptor address. The descriptor gives a new count, a new data address, a kind code and an interrupt flag, and it overwrites the upper half of the control word. The kind code and the interrupt flag decide whether this descriptor is the last one. When a zero count meets the end flag, the channel clears its start bit and pulses a finish strobe.

Memory is a synchronous read port: a request in one cycle returns data in the next. A narrow request returns a data word in bits 31:0 of the read bus. A wide request returns the 64-bit descriptor.

Top module: `dma_chain_walker`

## Requirements
- R1: A quadword is moved as four narrow reads at MADR, MADR+4, MADR+8 and MADR+12. Each read word is pushed the cycle after its read. Afterwards MADR rises by 16 and QWC falls by 1.
- R2: A quadword is started only when `fifo_level` is below FIFO_DEPTH-4. With the default depth of 16, a level of 11 lets a quadword start and a level of 12 stalls the channel.
- R3: While start (CTRL bit 8) is set, QWC is zero and the end flag is set, the channel finishes. While start is set, QWC is zero and the end flag is clear, it issues one wide read at TADR.
- R4: On a descriptor, QWC takes descriptor bits 15:0. CTRL bits 31:16 take descriptor bits 31:16, and CTRL bits 15:0 keep their value.
- R5: A descriptor kind (bits 30:28) of 3 loads MADR from descriptor bits 63:32 with bits 3:0 cleared, and advances TADR by 16. Kind 0 does the same and also sets the end flag.
- R6: A descriptor with bit 31 set sets the end flag only when CTRL bit 7 (descriptor-interrupt enable) is set. Without that enable, the chain continues.
- R7: A CTRL write (`reg_sel`=0) that raises start from 0 to 1 sets the end flag only if CTRL bits 3:2 (mode) are 0. Any other CTRL write clears the end flag.
- R8: On finish, CTRL bit 8 clears and `xfer_done` is high for exactly one cycle.
- R9: A descriptor read uses one wide access, and no word is pushed in that cycle.
- R10: After reset, all four registers are zero and `mem_req`, `fifo_push` and `xfer_done` are low.
- R11: A descriptor of any other kind still loads QWC and CTRL bits 31:16 and still applies R6. MADR and TADR are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 CTRL, 1 MADR, 2 QWC, 3 TADR |
| reg_wdata | input | 32 | Register write data |
| ctrl_q | output | 32 | CTRL register |
| madr_q | output | ADDR_W | Data address register |
| qwc_q | output | 16 | Quadword count register |
| tadr_q | output | ADDR_W | Descriptor address register |
| mem_req | output | 1 | Memory read request |
| mem_wide | output | 1 | 1 = 64-bit descriptor read, 0 = 32-bit data read |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdata | input | 64 | Read data, valid the cycle after the request |
| fifo_level | input | LVL_W | Current FIFO occupancy |
| fifo_push | output | 1 | FIFO push strobe |
| fifo_wdata | output | 32 | FIFO push data |
| xfer_done | output | 1 | One-cycle finish strobe |

## Verification
The bench uses the default parameters: a 32-bit address, a FIFO depth of 16, four words per quadword and 16-byte descriptor alignment. With depth 16 the start threshold falls at levels 11 and 12. Holding `fifo_level` at each of those values tests both sides of that threshold. The bench also rewrites CTRL during such a stall, so the end-flag clearing path is tested with data still pending.

// File: rtl/dwk_pkg.sv
package dwk_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_MADR = 2'd1,
      SEL_QWC  = 2'd2,
      SEL_TADR = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DATA,
      ST_DRAIN,
      ST_TAG
   } walk_st_e;

   localparam logic [2:0] KIND_LAST = 3'd0;
   localparam logic [2:0] KIND_JUMP = 3'd3;
   localparam int START_BIT   = 8;
   localparam int IEN_BIT     = 7;
   localparam int MODE_LO     = 2;
   localparam int TAG_STRIDE  = 16;

   typedef struct packed {
      logic [15:0] qwc;
      logic [15:0] ctrl_hi;
      logic        ld_addr;
      logic        set_end;
      logic [31:0] addr;
   } tag_info_t;

endpackage

// File: rtl/dwk_tag_decode.sv
module dwk_tag_decode
   import dwk_pkg::*;
#(
   parameter int ALIGN_BITS = 4
) (
   input  logic [63:0] tag,
   input  logic        irq_en,
   output tag_info_t   info
);
   logic [2:0]  kind;
   logic [31:0] raw_addr;
   logic [31:0] al_addr;

   assign kind     = tag[30:28];
   assign raw_addr = tag[63:32];

   generate
      if (ALIGN_BITS == 0) begin : g_noalign
         assign al_addr = raw_addr;
      end else begin : g_align
         assign al_addr = {raw_addr[31:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end
   endgenerate

   always_comb begin
      info.qwc     = tag[15:0];
      info.ctrl_hi = tag[31:16];
      info.ld_addr = (kind == KIND_LAST) || (kind == KIND_JUMP);
      info.set_end = (kind == KIND_LAST) || (tag[31] && irq_en);
      info.addr    = al_addr;
   end

   initial assert (ALIGN_BITS >= 0 && ALIGN_BITS < 32)
      else $error("ALIGN_BITS out of range");
endmodule

// File: rtl/dwk_beat_ctr.sv
module dwk_beat_ctr #(
   parameter int WORDS = 4,
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [IDX_W-1:0] idx,
   output logic             last
);
   assign last = (idx == IDX_W'(WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         idx <= '0;
      else if (adv)
         idx <= last ? '0 : idx + 1'b1;
   end

   initial assert (WORDS >= 2) else $error("WORDS must be at least 2");
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
   import dwk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int FIFO_DEPTH = 16,
   parameter int QW_WORDS   = 4,
   parameter int ALIGN_BITS = 4,
   localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       ctrl_q,
   output logic [ADDR_W-1:0] madr_q,
   output logic [15:0]       qwc_q,
   output logic [ADDR_W-1:0] tadr_q,
   output logic              mem_req,
   output logic              mem_wide,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [63:0]       mem_rdata,
   input  logic [LVL_W-1:0]  fifo_level,
   output logic              fifo_push,
   output logic [31:0]       fifo_wdata,
   output logic              xfer_done
);
   localparam int QW_BYTES = QW_WORDS * 4;
   localparam int IDX_W    = (QW_WORDS > 1) ? $clog2(QW_WORDS) : 1;
   localparam logic [LVL_W-1:0] ROOM_LIMIT = LVL_W'(FIFO_DEPTH - QW_WORDS);

   initial assert (FIFO_DEPTH > QW_WORDS) else $error("FIFO_DEPTH too small");
   initial assert (ADDR_W >= 8 && ADDR_W <= 32) else $error("ADDR_W out of range");

   walk_st_e         st;
   logic [31:0]      ctrl_r;
   logic [ADDR_W-1:0] madr_r, tadr_r;
   logic [15:0]      qwc_r;
   logic             end_r;
   logic             push_r;
   logic             done_r;
   logic [IDX_W-1:0] idx;
   logic             last;
   tag_info_t        ti;
   logic             running, room, go_data, go_fin, go_tag, qw_end;
   logic             wr_ctrl, wr_madr, wr_qwc, wr_tadr;

   dwk_beat_ctr #(.WORDS(QW_WORDS)) u_beat (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (go_data),
      .adv  (st == ST_DATA),
      .idx  (idx),
      .last (last)
   );

   dwk_tag_decode #(.ALIGN_BITS(ALIGN_BITS)) u_dec (
      .tag   (mem_rdata),
      .irq_en(ctrl_r[IEN_BIT]),
      .info  (ti)
   );

   always_comb begin
      running = ctrl_r[START_BIT];
      room    = fifo_level < ROOM_LIMIT;
      go_data = (st == ST_IDLE) && running && (qwc_r != '0) && room;
      go_fin  = (st == ST_IDLE) && running && (qwc_r == '0) && end_r;
      go_tag  = (st == ST_IDLE) && running && (qwc_r == '0) && !end_r;
      qw_end  = (st == ST_DATA) && last;
      wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
      wr_madr = reg_we && (reg_sel == SEL_MADR);
      wr_qwc  = reg_we && (reg_sel == SEL_QWC);
      wr_tadr = reg_we && (reg_sel == SEL_TADR);
   end

   assign mem_req    = (st == ST_DATA) || go_tag;
   assign mem_wide   = go_tag;
   assign mem_addr   = (st == ST_DATA) ? madr_r + (ADDR_W'(idx) << 2) : tadr_r;
   assign fifo_push  = push_r;
   assign fifo_wdata = mem_rdata[31:0];
   assign xfer_done  = done_r;
   assign ctrl_q     = ctrl_r;
   assign madr_q     = madr_r;
   assign qwc_q      = qwc_r;
   assign tadr_q     = tadr_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         push_r <= 1'b0;
         done_r <= 1'b0;
      end else begin
         push_r <= (st == ST_DATA);
         done_r <= go_fin;
         unique case (st)
            ST_IDLE:  if (go_data) st <= ST_DATA; else if (go_tag) st <= ST_TAG;
            ST_DATA:  if (last) st <= ST_DRAIN;
            ST_DRAIN: st <= ST_IDLE;
            ST_TAG:   st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_r <= '0;
         end_r  <= 1'b0;
      end else if (wr_ctrl) begin
         ctrl_r <= reg_wdata;
         end_r  <= (!ctrl_r[START_BIT] && reg_wdata[START_BIT])
                   ? (reg_wdata[MODE_LO+1:MODE_LO] == 2'b00) : 1'b0;
      end else if (go_fin) begin
         ctrl_r[START_BIT] <= 1'b0;
         end_r             <= 1'b0;
      end else if (st == ST_TAG) begin
         ctrl_r[31:16] <= ti.ctrl_hi;
         if (ti.set_end) end_r <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         madr_r <= '0;
         qwc_r  <= '0;
         tadr_r <= '0;
      end else begin
         if (wr_madr)                     madr_r <= reg_wdata[ADDR_W-1:0];
         else if (qw_end)                 madr_r <= madr_r + ADDR_W'(QW_BYTES);
         else if (st == ST_TAG && ti.ld_addr) madr_r <= ti.addr[ADDR_W-1:0];

         if (wr_qwc)                      qwc_r <= reg_wdata[15:0];
         else if (qw_end)                 qwc_r <= qwc_r - 16'd1;
         else if (st == ST_TAG)           qwc_r <= ti.qwc;

         if (wr_tadr)                     tadr_r <= reg_wdata[ADDR_W-1:0];
         else if (st == ST_TAG && ti.ld_addr) tadr_r <= tadr_r + ADDR_W'(TAG_STRIDE);
      end
   end

   AST_QW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN && !$past(reg_we)) |-> (qwc_r == $past(qwc_r) - 16'd1)) // R1
      else $error("quadword count step");
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> (fifo_level < LVL_W'(FIFO_DEPTH))) // R2
      else $error("push into full fifo");
   AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !$past(reg_we)) |-> !ctrl_q[START_BIT]) // R8
      else $error("start still set at finish");
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done) // R8
      else $error("finish strobe too long");
   AST_TAG_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_wide) |-> !fifo_push) // R9
      else $error("push during descriptor read");
endmodule

// File: tb/tb_dma_chain_walker.sv
module tb_dma_chain_walker;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;

   typedef struct packed {
      logic [31:0] madr;
      logic [15:0] qwc;
      logic [4:0]  lvl;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{madr: 32'h2000, qwc: 16'd1, lvl: 5'd0},
      '{madr: 32'h2100, qwc: 16'd3, lvl: 5'd11},
      '{madr: 32'h2208, qwc: 16'd2, lvl: 5'd3},
      '{madr: 32'h2300, qwc: 16'd0, lvl: 5'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] ctrl_q, madr_q, tadr_q;
   logic [15:0] qwc_q;
   logic        mem_req, mem_wide, fifo_push, xfer_done;
   logic [31:0] mem_addr, fifo_wdata;
   logic [63:0] mem_rdata = '0;
   logic [4:0]  fifo_level = '0;

   int tests = 0, fails = 0;
   int ncap = 0, donecnt = 0, pulse_err = 0, wide_push = 0;
   logic done_prev = 1'b0;
   logic [31:0] cap  [0:255];
   logic [31:0] expw [0:63];
   int nexp = 0;
   logic [63:0] tagmem [0:15];

   dma_chain_walker dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .madr_q(madr_q), .qwc_q(qwc_q),
      .tadr_q(tadr_q), .mem_req(mem_req), .mem_wide(mem_wide),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .fifo_level(fifo_level),
      .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .xfer_done(xfer_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] dval(input logic [31:0] a);
      return {~a[15:0], a[15:0]};
   endfunction

   always @(posedge clk) begin
      if (mem_req)
         mem_rdata <= mem_wide ? tagmem[mem_addr[7:4]] : {32'h0, dval(mem_addr)};
      if (fifo_push && ncap < 256) begin
         cap[ncap] <= fifo_wdata;
         ncap <= ncap + 1;
      end
      if (xfer_done) donecnt <= donecnt + 1;
      if (xfer_done && done_prev) pulse_err <= pulse_err + 1;
      if (mem_req && mem_wide && fifo_push) wide_push <= wide_push + 1;
      done_prev <= xfer_done;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wait_done(input int start);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (donecnt > start) break;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic add_qw(input logic [31:0] a);
      for (int k = 0; k < 4; k++) begin
         expw[nexp] = dval(a + 32'(k * 4));
         nexp++;
      end
   endtask

   task automatic cmp_words(input string tag, input int base);
      chk({tag, " word count"}, 32'(ncap - base), 32'(nexp));
      for (int i = 0; i < nexp; i++)
         chk({tag, " word"}, cap[base + i], expw[i]);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int base, d0;
      for (int i = 0; i < 16; i++) tagmem[i] = '0;
      // descriptors: kind in bits 30:28, irq bit 31, count 15:0, address 63:32
      tagmem[0]  = {32'h0000_2345, 32'h3000_0002};
      tagmem[1]  = {32'h0000_3008, 32'h0ABC_0001};
      tagmem[4]  = {32'h0000_2200, 32'hB000_0001};
      tagmem[6]  = {32'h0000_2400, 32'hB000_0001};
      tagmem[7]  = {32'h0000_2500, 32'h0000_0001};
      tagmem[8]  = {32'h0000_7770, 32'h9000_0001};
      tagmem[10] = {32'h0000_2800, 32'h0000_0001};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 ctrl", ctrl_q, 32'h0);
      chk("R10 madr", madr_q, 32'h0);
      chk("R10 qwc", 32'(qwc_q), 32'h0);
      chk("R10 tadr", tadr_q, 32'h0);
      chk("R10 outputs", {29'h0, mem_req, fifo_push, xfer_done}, 32'h0);

      // table: plain-mode transfers (R1, R2, R3, R8)
      for (int v = 0; v < 4; v++) begin
         base = ncap; d0 = donecnt; nexp = 0;
         fifo_level = VECS[v].lvl;
         wr(2'd1, VECS[v].madr);
         wr(2'd2, 32'(VECS[v].qwc));
         wr(2'd0, 32'h0000_0100);
         wait_done(d0);
         for (int q = 0; q < int'(VECS[v].qwc); q++) add_qw(VECS[v].madr + 32'(q * 16));
         cmp_words("R1 plain", base);
         chk("R1 madr step", madr_q, VECS[v].madr + 32'(VECS[v].qwc) * 16);
         chk("R1 qwc zero", 32'(qwc_q), 32'h0);
         chk("R3 finished once", 32'(donecnt - d0), 32'd1);
         chk("R8 start cleared", ctrl_q, 32'h0);
      end
      fifo_level = 0;

      // R5/R4/R3: two-descriptor chain, jump then last
      base = ncap; d0 = donecnt; nexp = 0;
      wr(2'd3, 32'h1000);
      wr(2'd0, 32'h0000_0104);
      wait_done(d0);
      add_qw(32'h2340); add_qw(32'h2350); add_qw(32'h3000);
      cmp_words("R5 chain", base);
      chk("R5 tadr advance", tadr_q, 32'h1020);
      chk("R5 madr aligned", madr_q, 32'h3010);
      chk("R4 ctrl upper copied", ctrl_q, 32'h0ABC_0004);
      chk("R9 no push on descriptor read", 32'(wide_push), 32'd0);

      // R6: irq bit with enable ends the chain
      base = ncap; d0 = donecnt; nexp = 0;
      wr(2'd3, 32'h1040);
      wr(2'd0, 32'h0000_0184);
      wait_done(d0);
      add_qw(32'h2200);
      cmp_words("R6 irq enabled", base);
      chk("R6 tadr", tadr_q, 32'h1050);
      chk("R6 ctrl", ctrl_q, 32'hB000_0084);

      // R6: irq bit without enable continues
      base = ncap; d0 = donecnt; nexp = 0;
      wr(2'd3, 32'h1060);
      wr(2'd0, 32'h0000_0104);
      wait_done(d0);
      add_qw(32'h2400); add_qw(32'h2500);
      cmp_words("R6 irq disabled", base);
      chk("R6 tadr no enable", tadr_q, 32'h1080);

      // R11: unknown kind keeps addresses
      base = ncap; d0 = donecnt; nexp = 0;
      wr(2'd1, 32'h2600);
      wr(2'd3, 32'h1080);
      wr(2'd0, 32'h0000_0184);
      wait_done(d0);
      add_qw(32'h2600);
      cmp_words("R11 unknown kind", base);
      chk("R11 tadr kept", tadr_q, 32'h1080);
      chk("R11 madr", madr_q, 32'h2610);
      chk("R11 ctrl upper", ctrl_q, 32'h9000_0084);

      // R2 stall at threshold, R7 rewrite clears end flag
      base = ncap; d0 = donecnt; nexp = 0;
      fifo_level = 5'(DEPTH - 4);
      wr(2'd1, 32'h2700);
      wr(2'd2, 32'd2);
      wr(2'd3, 32'h10A0);
      wr(2'd0, 32'h0000_0100);
      repeat (20) @(negedge clk);
      chk("R2 stall no push", 32'(ncap - base), 32'd0);
      chk("R2 stall qwc held", 32'(qwc_q), 32'd2);
      wr(2'd0, 32'h0000_0100);
      fifo_level = 0;
      wait_done(d0);
      add_qw(32'h2700); add_qw(32'h2710); add_qw(32'h2800);
      cmp_words("R7 rewrite clears end", base);
      chk("R7 tadr advanced", tadr_q, 32'h10B0);
      chk("R8 pulse width", 32'(pulse_err), 32'd0);
      chk("R9 no push on descriptor read", 32'(wide_push), 32'd0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule